// File: doc/BRIEF.md
# Eight-Level Nested Interrupt Controller

This block collects up to eight peripheral interrupt requests and hands them to a processor one at a time, in fixed priority order with nesting. A rising edge on a request line sets a bit in a pending-request register. A per-line mask hides pending bits from the resolver without discarding them. The resolver picks the lowest-numbered visible request. It raises `int_o` only when that level outranks every level already in service. Here "outranks" means that its index is smaller than the lowest set in-service index, or that nothing is in service.

The processor answers with two acknowledge pulses on `inta_i`. The first pulse moves the winner from the request register into the in-service register. The second pulse returns a vector byte: a programmed 5-bit base followed by the 3-bit level number. A command write ends service by clearing the highest-priority in-service bit.

Several controllers can be cascaded. A master flags the levels that have a slave attached. For such a level it drives the level number on its cascade output from the first pulse onward and stays silent on the data bus. A slave compares the cascade input with its own ID. It serves the sequence only when they match and skips both pulses when they do not.

The acknowledge sequencer has four states:
- ST_IDLE waits for a first pulse. It moves to ST_SKIP for an unselected slave. It moves to ST_PASS when a master commits a level that has a slave. Otherwise it moves to ST_SERVE.
- ST_SERVE, ST_PASS and ST_SKIP each return to ST_IDLE on the second pulse.
- Only ST_SERVE drives a vector.

Top module: `irq_hub`

## Requirements
- R1: After reset, `int_o` and `dout_en` are low, and the request, in-service and mask registers read zero.
- R2: A rising edge on `irq_in[n]` sets request bit n one clock later. A line held high does not set the bit again.
- R3: A masked level never raises `int_o` but stays in the request register. Masking a higher-priority level does not block a lower-priority one.
- R4: Among visible requests, the lowest index wins.
- R5: `int_o` is high exactly when a visible request exists and its index is below the lowest set in-service index, or nothing is in service.
- R6: The first acknowledge pulse sets the winner's in-service bit and clears its request bit. One clock after the second pulse, `dout_en` is high with `dout` = {base[4:0], level[2:0]}.
- R7: If no request is eligible at the first pulse, the in-service register is unchanged and the vector carries level 7.
- R8: The end-of-service command clears the lowest-indexed set in-service bit. This command is a write with `a0`=0 and data bits [7:6]=01.
- R9: Writes with `a0`=0 are decoded on data bits [7:6]:
  - 00 selects what an `a0`=0 read returns, using bit 0 (0 = requests, 1 = in-service).
  - 10 picks the target of later `a0`=1 writes, using bits [1:0] (0 = mask, 1 = vector base taken from data bits [7:3], 2 = cascade register).
  - 11 has no effect.
  A read with `a0`=1 returns the mask. Read data appears on `dout` with `dout_en` one clock after `rd_en`.
- R10: With `role_master` high, `cas_oe` is high. When the committed level's cascade-register bit is set, `cas_o` holds that level from the first pulse through the second, and no vector is driven.
- R11: With `role_master` low, `cas_oe` is low. If `cas_i` differs from cascade-register bits [2:0] at the first pulse, both pulses are ignored and no state changes. On a match, the slave serves as in R6.
- R12: `dout_en` is high only after a read or a served second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| a0 | input | 1 | Register address line |
| wdata | input | 8 | Write data |
| irq_in | input | 8 | Request lines, edge sensitive |
| inta_i | input | 1 | Acknowledge pulse, one clock per pulse |
| role_master | input | 1 | High: master, low: slave |
| cas_i | input | 3 | Cascade ID seen by a slave |
| int_o | output | 1 | Interrupt to the processor |
| dout | output | 8 | Read data or vector |
| dout_en | output | 1 | `dout` valid |
| cas_o | output | 3 | Cascade ID driven by a master |
| cas_oe | output | 1 | Cascade output enable |

## Verification
The hardest situation to reach is a nested state where the in-service register holds a mid-priority level while lower and higher requests are pending, some of them masked. Only then do the nesting comparison, the spurious-vector path and the end-of-service ordering all matter together. The directed part builds this deliberately: it services level 1, raises level 0 over it, and ends service in priority order. The seeded random phase then interleaves edges, mask rewrites, acknowledge pairs and end-of-service commands, so that many such in-service mixes arise. The cascade paths need the role pin and `cas_i` to be steered by the bench, and they are covered by directed master and slave sequences.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_PASS  = 2'd2,
        ST_SKIP  = 2'd3
    } ack_state_t;

    typedef enum logic [1:0] {
        OP_RDSEL  = 2'b00,
        OP_EOI    = 2'b01,
        OP_TARGET = 2'b10,
        OP_NONE   = 2'b11
    } cmd_op_t;

    typedef enum logic [1:0] {
        TG_MASK = 2'd0,
        TG_BASE = 2'd1,
        TG_CASC = 2'd2,
        TG_RSVD = 2'd3
    } target_t;
endpackage

// File: rtl/irq_hub_prio.sv
`timescale 1ns/1ps
module irq_hub_prio #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] bits,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = W'(i);
        end
    end

    assign any = |bits;
endmodule

// File: rtl/irq_hub_req.sv
`timescale 1ns/1ps
module irq_hub_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                        pend[g] <= 1'b0;
            else if (lines[g] && !prev_q[g])   pend[g] <= 1'b1;
            else if (clr[g])                   pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_hub_regs.sv
`timescale 1ns/1ps
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    output logic [N-1:0]      mask,
    output logic [DATA_W-LW-1:0] base,
    output logic [N-1:0]      casc,
    output logic              rdsel_isr,
    output logic              eoi
);
    target_t tgt_q;
    cmd_op_t op;

    assign op  = cmd_op_t'(wdata[7:6]);
    assign eoi = wr_en && !a0 && (op == OP_EOI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '0;
            base      <= '0;
            casc      <= '0;
            rdsel_isr <= 1'b0;
            tgt_q     <= TG_MASK;
        end else if (wr_en && !a0) begin
            unique case (op)
                OP_RDSEL:  rdsel_isr <= wdata[0];
                OP_TARGET: tgt_q     <= target_t'(wdata[1:0]);
                OP_EOI, OP_NONE: ;
            endcase
        end else if (wr_en && a0) begin
            unique case (tgt_q)
                TG_MASK: mask <= wdata[N-1:0];
                TG_BASE: base <= wdata[DATA_W-1:LW];
                TG_CASC: casc <= wdata[N-1:0];
                TG_RSVD: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int LVLS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     a0,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [LVLS-1:0]          irq_in,
    input  logic                     inta_i,
    input  logic                     role_master,
    input  logic [$clog2(LVLS)-1:0]  cas_i,
    output logic                     int_o,
    output logic [DATA_W-1:0]        dout,
    output logic                     dout_en,
    output logic [$clog2(LVLS)-1:0]  cas_o,
    output logic                     cas_oe
);
    localparam int LW = $clog2(LVLS);
    localparam int BW = DATA_W - LW;

    ack_state_t          state, nxt;
    logic [LVLS-1:0]     irr, isr_q, mask, casc, vis, clr_vec, eoi_vec, set_vec;
    logic [BW-1:0]       base;
    logic [LW-1:0]       win_idx, isr_top, lvl_q;
    logic                win_any, isr_any, rdsel_isr, eoi_pulse;
    logic                eligible, slave_sel, is_casc, first_pulse, commit;

    irq_hub_req #(.N(LVLS)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .clr(clr_vec), .pend(irr)
    );

    irq_hub_regs #(.N(LVLS), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wdata(wdata),
        .mask(mask), .base(base), .casc(casc), .rdsel_isr(rdsel_isr), .eoi(eoi_pulse)
    );

    assign vis = irr & ~mask;

    irq_hub_prio #(.N(LVLS), .W(LW)) u_win (.bits(vis),   .any(win_any), .idx(win_idx));
    irq_hub_prio #(.N(LVLS), .W(LW)) u_top (.bits(isr_q), .any(isr_any), .idx(isr_top));

    // nesting rule: winner must outrank the highest level in service
    assign eligible    = win_any && (!isr_any || (win_idx < isr_top));
    assign int_o       = eligible;
    assign slave_sel   = (cas_i == casc[LW-1:0]);
    assign is_casc     = role_master && casc[win_idx];
    assign first_pulse = (state == ST_IDLE) && inta_i;
    assign commit      = first_pulse && eligible && (role_master || slave_sel);

    assign set_vec = commit ? (LVLS'(1) << win_idx) : '0;
    assign clr_vec = set_vec;
    assign eoi_vec = (eoi_pulse && isr_any) ? (LVLS'(1) << isr_top) : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (inta_i) begin
                    if (!role_master && !slave_sel) nxt = ST_SKIP;
                    else if (eligible && is_casc)   nxt = ST_PASS;
                    else                            nxt = ST_SERVE;
                end
            end
            ST_SERVE, ST_PASS, ST_SKIP: begin
                if (inta_i) nxt = ST_IDLE;
            end
        endcase
    end

    // in-service register and latched level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            lvl_q <= '0;
        end else begin
            isr_q <= (isr_q & ~eoi_vec) | set_vec;
            if (first_pulse) lvl_q <= eligible ? win_idx : LW'(LVLS - 1);
        end
    end

    // cascade outputs
    assign cas_oe = role_master;
    assign cas_o  = !role_master      ? '0 :
                    (state == ST_PASS) ? lvl_q : win_idx;

    // data outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else if (state == ST_SERVE && inta_i) begin
            dout    <= {base, lvl_q};
            dout_en <= 1'b1;
        end else if (rd_en) begin
            dout    <= a0 ? DATA_W'(mask) : (rdsel_isr ? DATA_W'(isr_q) : DATA_W'(irr));
            dout_en <= 1'b1;
        end else begin
            dout_en <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int LVLS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    inta_i,
    input logic                    rd_en,
    input logic                    int_o,
    input logic                    dout_en,
    input logic [$clog2(LVLS)-1:0] cas_o,
    input ack_state_t              state,
    input logic [LVLS-1:0]         isr,
    input logic                    eoi
);
    p_vector_after_serve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE && inta_i) |=> dout_en);

    p_isr_grows_by_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && inta_i && !eoi) |=> ($countones(isr) <= $past($countones(isr)) + 1));

    p_top_blocks_int_r5: assert property (@(posedge clk) disable iff (!rst_n)
        isr[0] |-> !int_o);

    p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (isr != '0) && !(state == ST_IDLE && inta_i))
        |=> ($countones(isr) + 1 == $past($countones(isr))));

    p_pass_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && inta_i && !rd_en) |=> !dout_en);

    p_pass_cas_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && !inta_i) |=> $stable(cas_o));

    p_skip_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && inta_i && !rd_en) |=> !dout_en);

    p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !(state == ST_SERVE && inta_i)) |=> !dout_en);
endmodule

bind irq_hub irq_hub_chk #(.LVLS(LVLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .rd_en(rd_en), .int_o(int_o),
    .dout_en(dout_en), .cas_o(cas_o), .state(state), .isr(isr_q), .eoi(eoi_pulse)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
    logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, a0 = 0, inta_i = 0, role_master = 1;
    logic [7:0] wdata = 0, irq_in = 0;
    logic [2:0] cas_i = 0;
    logic       int_o, dout_en, cas_oe;
    logic [7:0] dout;
    logic [2:0] cas_o;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_casc = 0;
    logic [4:0] m_base = 0;

    irq_hub u_irq_hub (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] b);
        for (int i = 0; i < 8; i++) if (b[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_int();
        int w = lowest(m_irr & ~m_imr);
        return (w < 8) && (w < lowest(m_isr));
    endfunction

    task automatic wr(input logic ad, input logic [7:0] d);
        wr_en = 1; a0 = ad; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic ad, output logic [7:0] d, output logic en);
        rd_en = 1; a0 = ad;
        @(negedge clk);
        d = dout; en = dout_en; rd_en = 0;
    endtask

    task automatic read_reg(input logic [7:0] sel, output logic [7:0] d);
        logic en;
        if (sel == 8'hFF) rd(1, d, en);
        else begin wr(0, sel); rd(0, d, en); end
    endtask

    task automatic pulse(input logic [7:0] b);
        irq_in = b;
        @(negedge clk);
        irq_in = 0;
        m_irr |= b;
    endtask

    task automatic set_reg(input logic [1:0] tgt, input logic [7:0] d);
        wr(0, {6'b100000, tgt});
        wr(1, d);
    endtask

    task automatic do_inta(output logic en, output logic [7:0] v, output logic [2:0] cm);
        inta_i = 1; @(negedge clk); inta_i = 0; cm = cas_o;
        @(negedge clk);
        inta_i = 1; @(negedge clk); inta_i = 0; en = dout_en; v = dout;
    endtask

    task automatic eoi();
        int t = lowest(m_isr);
        wr(0, 8'h40);
        if (t < 8) m_isr[t] = 0;
    endtask

    // R6/R7/R10: service one acknowledge pair against the model (master role)
    task automatic service();
        logic en; logic [7:0] v; logic [2:0] cm; logic [7:0] ev; logic hit;
        int w = lowest(m_irr & ~m_imr);
        if (w < 8 && w < lowest(m_isr)) begin
            m_isr[w] = 1; m_irr[w] = 0; ev = {m_base, 3'(w)}; hit = m_casc[w];
        end else begin
            ev = {m_base, 3'd7}; hit = 0;
        end
        do_inta(en, v, cm);
        if (hit) chk("R10 pass no vector", en, 0);
        else begin
            chk("R6 vector valid", en, 1);
            chk("R6 R7 vector value", v, ev);
        end
    endtask

    initial begin
        logic [7:0] d; logic en; logic [7:0] v; logic [2:0] cm;
        int r;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 int low", int_o, 0);
        chk("R1 dout_en low", dout_en, 0);
        read_reg(8'h00, d); chk("R1 request reg", d, 0);
        read_reg(8'h01, d); chk("R1 in-service reg", d, 0);
        read_reg(8'hFF, d); chk("R1 mask reg", d, 0);
        chk("R10 cas_oe master", cas_oe, 1);

        set_reg(2'd1, 8'hA8); m_base = 5'b10101;

        // R2 edge capture
        pulse(8'h20);
        read_reg(8'h00, d); chk("R2 request bit 5", d, 8'h20);
        chk("R5 int raised", int_o, 1);
        irq_in = 8'h40; repeat (4) @(negedge clk);
        m_irr |= 8'h40;
        read_reg(8'h00, d); chk("R2 held line sets once", d, 8'h60);
        irq_in = 0; @(negedge clk);

        // R4 priority, R6 commit
        pulse(8'h0A);
        service();
        read_reg(8'h01, d); chk("R6 in-service bit 1", d, 8'h02);
        read_reg(8'h00, d); chk("R6 request bit cleared", d, 8'h68);
        chk("R5 lower level blocked", int_o, 0);

        // R5 nesting over level 1
        pulse(8'h01);
        chk("R5 higher level raises int", int_o, 1);
        service();
        read_reg(8'h01, d); chk("R5 nested in-service", d, 8'h03);

        // R8 end of service in priority order
        eoi();
        read_reg(8'h01, d); chk("R8 clears level 0 first", d, 8'h02);
        eoi();
        read_reg(8'h01, d); chk("R8 clears level 1", d, 8'h00);
        chk("R5 int back for level 3", int_o, 1);

        // R3 masking
        set_reg(2'd0, 8'h08); m_imr = 8'h08;
        chk("R3 lower level passes mask", int_o, 1);
        set_reg(2'd0, 8'h68); m_imr = 8'h68;
        chk("R3 all masked int low", int_o, 0);
        read_reg(8'h00, d); chk("R3 masked bits kept", d, 8'h68);
        read_reg(8'hFF, d); chk("R9 mask readback", d, 8'h68);
        wr(0, 8'hC3);
        read_reg(8'hFF, d); chk("R9 op 11 no effect", d, 8'h68);

        // R7 spurious acknowledge
        service();
        read_reg(8'h01, d); chk("R7 in-service unchanged", d, 8'h00);

        set_reg(2'd0, 8'h00); m_imr = 0;
        for (int k = 0; k < 12; k++) begin service(); eoi(); end

        // R10 master cascade
        set_reg(2'd2, 8'h04); m_casc = 8'h04;
        pulse(8'h04);
        do_inta(en, v, cm); m_isr[2] = 1; m_irr[2] = 0;
        chk("R10 cas carries level", cm, 3'd2);
        chk("R10 no vector", en, 0);
        read_reg(8'h01, d); chk("R10 in-service set", d, 8'h04);
        eoi();
        set_reg(2'd2, 8'h00); m_casc = 0;

        // R11 slave
        role_master = 0;
        set_reg(2'd2, 8'h05);
        chk("R11 cas_oe slave", cas_oe, 0);
        pulse(8'h08);
        cas_i = 3'd2;
        do_inta(en, v, cm);
        chk("R11 unselected no vector", en, 0);
        read_reg(8'h01, d); chk("R11 unselected in-service", d, 8'h00);
        read_reg(8'h00, d); chk("R11 unselected request kept", d, 8'h08);
        cas_i = 3'd5;
        do_inta(en, v, cm); m_isr[3] = 1; m_irr[3] = 0;
        chk("R11 selected vector valid", en, 1);
        chk("R11 selected vector", v, 8'hAB);
        eoi();
        role_master = 1; cas_i = 0;
        set_reg(2'd2, 8'h00);

        // random phase
        for (int it = 0; it < 400; it++) begin
            r = $urandom % 4;
            case (r)
                0: pulse(8'($urandom & $urandom));
                1: begin
                    d = 8'($urandom & $urandom & $urandom);
                    set_reg(2'd0, d); m_imr = d;
                end
                2: service();
                default: eoi();
            endcase
            chk("R5 int vs model", int_o, exp_int());
            @(negedge clk);
            chk("R12 bus idle", dout_en, 0);
            if (it % 16 == 0) begin
                read_reg(8'h00, d); chk("R2 request reg random", d, m_irr);
                read_reg(8'h01, d); chk("R6 in-service random", d, m_isr);
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule